// File: doc/BRIEF.md
# PLL Multiplier Shift-Code Converter

This block converts between the plain binary feedback multiplier of a PLL and the 17-bit scrambled code that the PLL's configuration register holds. Apart from two small multipliers that have fixed special codes, the code is the state of a 15-bit shift register after a given number of steps. The step count depends on the multiplier. An encode request steps the register forward from a fixed seed. It also derives the proportional and integral loop-bandwidth selects from the binary multiplier and packs all three fields into one configuration word.

A decode request takes a stored code and steps the register backward until it reaches the seed. A counter falls by one on each step, and the counter's final value is the multiplier. A code that the sequence never reaches ends with the counter at zero, and the block flags it as invalid. The block handles one request at a time and reports completion with a one-cycle done pulse. It has four states:

- `ST_IDLE` waits for a request.
- `ST_ENC_DIV` runs the iterative ceiling divider that the integral select needs.
- `ST_ENC_RUN` steps the shift register forward.
- `ST_DEC_RUN` steps it backward.

The transitions are:

- **accept-encode**: `ST_IDLE` to `ST_ENC_DIV` on `enc_start`.
- **accept-decode**: `ST_IDLE` to `ST_DEC_RUN` on `dec_start` when `enc_start` is low.
- **divide-done**: `ST_ENC_DIV` to `ST_ENC_RUN` when the divider reports ready.
- **encode-done**: `ST_ENC_RUN` to `ST_IDLE` when the step count is reached or the multiplier has a special code.
- **decode-done**: `ST_DEC_RUN` to `ST_IDLE` when one of these holds:
  - the register equals the seed;
  - the counter is zero;
  - the code was special.

Top module: `pll_mult_codec`

## Requirements
- R1: After reset, `busy`, `enc_done` and `dec_done` are 0, and `enc_word`, `dec_mult` and `dec_invalid` are 0.
- R2: Encoding multiplier 0 gives code 0x00000, multiplier 1 gives 0x18003, and multiplier 2 gives 0x10003. For these three, `enc_done` rises on the 12th rising edge after the edge that accepted the start.
- R3: For a multiplier M of 3 or more, the code starts at 0x4000 and takes S forward steps. S = 32769-M when M ≤ 32768, and S = 0 otherwise. One forward step shifts the 15-bit state right by one and writes bit0 XOR bit1 into bit 14. The code sits in `enc_word[16:0]`, and `enc_done` rises on edge 12+S after the accepting edge.
- R4: `enc_word[21:17]` holds the proportional select. It is M/2+1 (integer division) when M < 60, and 31 otherwise.
- R5: `enc_word[27:22]` holds the integral select. The first rule that matches applies:
  - M > 16384 gives 1.
  - M > 8192 gives 2.
  - M > 2048 gives 4.
  - M ≥ 501 gives 8.
  - M ≥ 60 gives 4·ceil(1024/(M+9)).
  - Otherwise it is (M AND 0x3C)+4.
- R6: Decoding 0x18003 gives 1 and decoding 0x10003 gives 2. In both cases `dec_done` rises on the first edge after the accepting edge.
- R7: Decoding any other code starts a counter at 32769. While the register is not 0x04000 (all 17 bits compared) and the counter is not zero, one backward step and one decrement happen per cycle. A backward step shifts the low 15 bits left by one and writes bit0 XOR bit14 into bit 0. `dec_mult` is the final counter value, and `dec_done` rises on edge 1+S, where S is the number of steps.
- R8: `dec_invalid` is 1 with a decode result of 0 and 0 otherwise. It holds until the next decode completes.
- R9: `busy` is high from the edge that accepts a start until the edge that raises the done pulse. Starts that arrive while busy are ignored and change no output.
- R10: If `enc_start` and `dec_start` are both high while idle, the encode is taken and the decode is dropped.
- R11: Each done pulse lasts one cycle. `enc_word` changes only when `enc_done` rises, and `dec_mult` changes only when `dec_done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_start | input | 1 | Encode request, sampled while idle |
| enc_mult | input | 16 | Binary multiplier to encode |
| dec_start | input | 1 | Decode request, sampled while idle |
| dec_code | input | 17 | Scrambled code to decode |
| busy | output | 1 | A conversion is in progress |
| enc_done | output | 1 | One-cycle pulse: `enc_word` updated |
| enc_word | output | 28 | Packed word: integral select, proportional select, code |
| dec_done | output | 1 | One-cycle pulse: `dec_mult` updated |
| dec_mult | output | 16 | Decoded multiplier |
| dec_invalid | output | 1 | Last decode did not reach the seed |

## Verification
A wrong register state shows at the ports in one of two ways. A miscounted step moves the done pulse away from the expected edge, and a wrong feedback tap changes the code in `enc_word[16:0]` or the value in `dec_mult`. The bench models the expected edge for every request, so a step-count error is caught on the first cycle where `busy` or a done pulse disagrees, long before the long runs end. A wrong divider quotient can only be seen in the integral-select field on `enc_done`. Round-trip decodes of codes produced by encoding check that the forward and backward steps are inverses of each other.

// File: rtl/mdec_conv_pkg.sv
package mdec_conv_pkg;
    localparam int MULT_W   = 16;
    localparam int CODE_W   = 17;
    localparam int LFSR_W   = 15;
    localparam int SELP_W   = 5;
    localparam int SELI_W   = 6;
    localparam int WORD_W   = CODE_W + SELP_W + SELI_W;
    localparam int MULT_MAX = 32768;
    localparam int DEC_INIT = MULT_MAX + 1;
    // the integral-select division uses 2**DIV_W as its dividend
    localparam int DIV_W    = 10;

    localparam logic [CODE_W-1:0] SEED_CODE = 17'h04000;
    localparam logic [CODE_W-1:0] CODE_ONE  = 17'h18003;
    localparam logic [CODE_W-1:0] CODE_TWO  = 17'h10003;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENC_DIV,
        ST_ENC_RUN,
        ST_DEC_RUN
    } conv_state_e;
endpackage

// File: rtl/mdec_lfsr_step.sv
module mdec_lfsr_step
    import mdec_conv_pkg::*;
(
    input  logic [LFSR_W-1:0] fwd_cur,
    output logic [LFSR_W-1:0] fwd_next,
    input  logic [LFSR_W-1:0] bwd_cur,
    output logic [LFSR_W-1:0] bwd_next
);
    // forward: shift toward bit 0, feedback into the top bit
    assign fwd_next = {fwd_cur[0] ^ fwd_cur[1], fwd_cur[LFSR_W-1:1]};
    // backward: shift toward the top bit, feedback into bit 0
    assign bwd_next = {bwd_cur[LFSR_W-2:0], bwd_cur[0] ^ bwd_cur[LFSR_W-1]};
endmodule

// File: rtl/mdec_ceil_div.sv
module mdec_ceil_div
    import mdec_conv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] divisor_in,
    output logic [DIV_W-1:0] quot,
    output logic             ready
);
    localparam int CNT_W = $clog2(DIV_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_W);

    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] rem;
    logic [CNT_W-1:0] iter;
    logic [DIV_W:0]   trial;
    logic [DIV_W:0]   diff;
    logic             fits;

    // dividend is 2**DIV_W - 1, so every shifted-in bit is 1
    assign trial = {rem, 1'b1};
    assign diff  = trial - {1'b0, divisor};
    assign fits  = trial >= {1'b0, divisor};
    assign ready = (iter == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divisor <= '0;
            rem     <= '0;
            quot    <= '0;
            iter    <= LAST;
        end else if (load) begin
            divisor <= divisor_in;
            rem     <= '0;
            quot    <= '0;
            iter    <= '0;
        end else if (!ready) begin
            rem  <= fits ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
            quot <= {quot[DIV_W-2:0], fits};
            iter <= iter + 1'b1;
        end
    end

    // R5: the partial remainder stays below the divisor after each iteration
    a_r5_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !ready) |=> (rem < divisor));
endmodule

// File: rtl/mdec_bw_select.sv
module mdec_bw_select
    import mdec_conv_pkg::*;
(
    input  logic [MULT_W-1:0] mult,
    input  logic [DIV_W-1:0]  quot,
    output logic [SELP_W-1:0] selp,
    output logic [SELI_W-1:0] seli
);
    always_comb begin
        if (mult < MULT_W'(60)) selp = SELP_W'(mult[5:1]) + SELP_W'(1);
        else                    selp = SELP_W'(31);

        if (mult > MULT_W'(16384))     seli = SELI_W'(1);
        else if (mult > MULT_W'(8192)) seli = SELI_W'(2);
        else if (mult > MULT_W'(2048)) seli = SELI_W'(4);
        else if (mult >= MULT_W'(501)) seli = SELI_W'(8);
        else if (mult >= MULT_W'(60))  seli = SELI_W'((quot + DIV_W'(1)) << 2);
        else                           seli = SELI_W'({mult[5:2], 2'b00}) + SELI_W'(4);
    end
endmodule

// File: rtl/pll_mult_codec.sv
module pll_mult_codec
    import mdec_conv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_start,
    input  logic [MULT_W-1:0] enc_mult,
    input  logic              dec_start,
    input  logic [CODE_W-1:0] dec_code,
    output logic              busy,
    output logic              enc_done,
    output logic [WORD_W-1:0] enc_word,
    output logic              dec_done,
    output logic [MULT_W-1:0] dec_mult,
    output logic              dec_invalid
);
    conv_state_e state, state_nx;

    logic [MULT_W-1:0] enc_m;
    logic [MULT_W:0]   enc_i;
    logic [LFSR_W-1:0] enc_x;
    logic [CODE_W-1:0] dec_x;
    logic [MULT_W-1:0] dec_cnt;
    logic [1:0]        dec_sp;

    logic [LFSR_W-1:0] fwd_next, bwd_next;
    logic [DIV_W-1:0]  quot;
    logic              div_ready, div_load;
    logic [SELP_W-1:0] selp;
    logic [SELI_W-1:0] seli;
    logic              enc_finish, dec_finish;
    logic [CODE_W-1:0] enc_code;
    logic [MULT_W-1:0] dec_res;

    mdec_lfsr_step u_step (
        .fwd_cur  (enc_x),
        .fwd_next (fwd_next),
        .bwd_cur  (dec_x[LFSR_W-1:0]),
        .bwd_next (bwd_next)
    );

    assign div_load = (state == ST_IDLE) && enc_start;

    mdec_ceil_div u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (div_load),
        .divisor_in (DIV_W'(enc_mult[8:0]) + DIV_W'(9)),
        .quot       (quot),
        .ready      (div_ready)
    );

    mdec_bw_select u_sel (
        .mult (enc_m),
        .quot (quot),
        .selp (selp),
        .seli (seli)
    );

    assign enc_finish = (enc_m < MULT_W'(3)) || (enc_i > (MULT_W+1)'(MULT_MAX));
    assign dec_finish = (dec_sp != 2'd0) || (dec_x == SEED_CODE) || (dec_cnt == '0);
    assign busy       = (state != ST_IDLE);

    always_comb begin
        unique case (enc_m)
            MULT_W'(0): enc_code = '0;
            MULT_W'(1): enc_code = CODE_ONE;
            MULT_W'(2): enc_code = CODE_TWO;
            default:    enc_code = CODE_W'(enc_x);
        endcase
        unique case (dec_sp)
            2'd1:    dec_res = MULT_W'(1);
            2'd2:    dec_res = MULT_W'(2);
            default: dec_res = dec_cnt;
        endcase
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (enc_start)      state_nx = ST_ENC_DIV;
                        else if (dec_start) state_nx = ST_DEC_RUN;
            ST_ENC_DIV: if (div_ready)      state_nx = ST_ENC_RUN;
            ST_ENC_RUN: if (enc_finish)     state_nx = ST_IDLE;
            ST_DEC_RUN: if (dec_finish)     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_m       <= '0;
            enc_i       <= '0;
            enc_x       <= '0;
            dec_x       <= '0;
            dec_cnt     <= '0;
            dec_sp      <= 2'd0;
            enc_done    <= 1'b0;
            enc_word    <= '0;
            dec_done    <= 1'b0;
            dec_mult    <= '0;
            dec_invalid <= 1'b0;
        end else begin
            enc_done <= 1'b0;
            dec_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (enc_start) begin
                        enc_m <= enc_mult;
                        enc_i <= {1'b0, enc_mult};
                        enc_x <= SEED_CODE[LFSR_W-1:0];
                    end else if (dec_start) begin
                        dec_x   <= dec_code;
                        dec_cnt <= MULT_W'(DEC_INIT);
                        dec_sp  <= (dec_code == CODE_ONE) ? 2'd1 :
                                   (dec_code == CODE_TWO) ? 2'd2 : 2'd0;
                    end
                end
                ST_ENC_DIV: ;
                ST_ENC_RUN: begin
                    if (enc_finish) begin
                        enc_done <= 1'b1;
                        enc_word <= {seli, selp, enc_code};
                    end else begin
                        enc_x <= fwd_next;
                        enc_i <= enc_i + 1'b1;
                    end
                end
                ST_DEC_RUN: begin
                    if (dec_finish) begin
                        dec_done    <= 1'b1;
                        dec_mult    <= dec_res;
                        dec_invalid <= (dec_res == '0);
                    end else begin
                        dec_x   <= CODE_W'(bwd_next);
                        dec_cnt <= dec_cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // R3: a running forward register never collapses to all zeros
    a_r3_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENC_RUN) |-> (enc_x != '0));

    // R7: each cycle spent stepping backward lowers the counter by one
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC_RUN && $past(state) == ST_DEC_RUN)
            |-> (dec_cnt == $past(dec_cnt) - MULT_W'(1)));

    // R9: busy only rises after an accepted start
    a_r9_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(enc_start || dec_start));

    // R9: a completion leaves the block idle
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_done || dec_done) |-> !busy);

    // R10: encode wins over a simultaneous decode
    a_r10_enc_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && enc_start && dec_start) |=> (state == ST_ENC_DIV));

    // R11: done pulses last exactly one cycle
    a_r11_enc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        enc_done |=> !enc_done);
    a_r11_dec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> !dec_done);
endmodule

// File: tb/pll_mult_codec_test.sv
`timescale 1ns/1ps
module pll_mult_codec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_start = 1'b0;
    logic [15:0] enc_mult = '0;
    logic        dec_start = 1'b0;
    logic [16:0] dec_code = '0;
    logic        busy, enc_done, dec_done, dec_invalid;
    logic [27:0] enc_word;
    logic [15:0] dec_mult;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pll_mult_codec uut (
        .clk(clk), .rst_n(rst_n),
        .enc_start(enc_start), .enc_mult(enc_mult),
        .dec_start(dec_start), .dec_code(dec_code),
        .busy(busy), .enc_done(enc_done), .enc_word(enc_word),
        .dec_done(dec_done), .dec_mult(dec_mult), .dec_invalid(dec_invalid)
    );

    task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    task automatic ref_encode(input int m, output logic [27:0] w, output int s);
        int x, code, selp, seli;
        s = 0;
        if (m == 0) code = 0;
        else if (m == 1) code = 'h18003;
        else if (m == 2) code = 'h10003;
        else begin
            x = 'h4000;
            for (int i = m; i <= 32768; i++) begin
                x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'hffff);
                s++;
            end
            code = x;
        end
        selp = (m < 60) ? (m / 2 + 1) : 31;
        if (m > 16384) seli = 1;
        else if (m > 8192) seli = 2;
        else if (m > 2048) seli = 4;
        else if (m >= 501) seli = 8;
        else if (m >= 60) seli = 4 * ((1024 + m + 8) / (m + 9));
        else seli = (m & 'h3c) + 4;
        w = {seli[5:0], selp[4:0], code[16:0]};
    endtask

    task automatic ref_decode(input int c, output int res, output int s);
        int x, i;
        s = 0;
        if (c == 'h18003) res = 1;
        else if (c == 'h10003) res = 2;
        else begin
            x = c; i = 32769;
            while (x != 'h4000 && i > 0) begin
                x = ((x ^ (x >> 14)) & 1) | ((x << 1) & 'h7fff);
                i--; s++;
            end
            res = i;
        end
    endtask

    // behavioural cycle model
    int          m_state = 0;
    int          m_cnt = 0;
    int          p_mult = 0;
    int          p_dmult = 0;
    int          m_dmult = 0;
    int          steps;
    logic [27:0] p_word = '0;
    logic [27:0] m_word = '0;
    bit          m_edone = 0, m_ddone = 0, m_inv = 0;
    int          last_mult = 0;

    always @(posedge clk) begin
        m_edone = 0;
        m_ddone = 0;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_word = '0; m_dmult = 0; m_inv = 0;
        end else if (m_state != 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                if (m_state == 1) begin
                    m_edone = 1; m_word = p_word; last_mult = p_mult;
                end else begin
                    m_ddone = 1; m_dmult = p_dmult; m_inv = (p_dmult == 0);
                end
                m_state = 0;
            end
        end else if (enc_start) begin
            ref_encode(int'(enc_mult), p_word, steps);
            p_mult = int'(enc_mult);
            m_cnt = 12 + steps;
            m_state = 1;
        end else if (dec_start) begin
            ref_decode(int'(dec_code), p_dmult, steps);
            m_cnt = 1 + steps;
            m_state = 2;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        chk(busy == (m_state != 0), "R9 busy", busy, m_state != 0);
        chk(enc_done == m_edone, "R11 enc_done", enc_done, m_edone);
        chk(dec_done == m_ddone, "R11 dec_done", dec_done, m_ddone);
        if (last_mult < 3)
            chk(enc_word[16:0] == m_word[16:0], "R2 code", enc_word[16:0], m_word[16:0]);
        else
            chk(enc_word[16:0] == m_word[16:0], "R3 code", enc_word[16:0], m_word[16:0]);
        chk(enc_word[21:17] == m_word[21:17], "R4 selp", enc_word[21:17], m_word[21:17]);
        chk(enc_word[27:22] == m_word[27:22], "R5 seli", enc_word[27:22], m_word[27:22]);
        chk(int'(dec_mult) == (m_dmult & 'hffff), "R7 dec_mult", dec_mult, m_dmult);
        chk(dec_invalid == m_inv, "R8 invalid", dec_invalid, m_inv);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 199000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic wait_idle();
        while (m_state != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_enc(input int m);
        @(negedge clk);
        enc_mult = 16'(m); enc_start = 1'b1;
        @(negedge clk);
        enc_start = 1'b0;
        wait_idle();
    endtask

    task automatic run_dec(input int c);
        @(negedge clk);
        dec_code = 17'(c); dec_start = 1'b1;
        @(negedge clk);
        dec_start = 1'b0;
        wait_idle();
    endtask

    logic [27:0] tmp_w;
    int          tmp_s;
    logic [15:0] held_mult;
    logic [27:0] held_word;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !enc_done && !dec_done, "R1 flags", {busy, enc_done, dec_done}, 0);
        chk(enc_word == '0 && dec_mult == '0 && !dec_invalid, "R1 outputs", enc_word, 0);

        // R2: special encodes
        run_enc(0); run_enc(1); run_enc(2);
        // R3: short forward runs and above-maximum input
        run_enc(32768); run_enc(32767); run_enc(40000); run_enc(32000);
        // R4/R5 ranges
        run_enc(20000);
        run_enc(16384);
        run_enc(8192);
        run_enc(500);
        run_enc(59);

        // R6: special decodes
        run_dec('h18003);
        run_dec('h10003);
        // R7: round trips
        ref_encode(32000, tmp_w, tmp_s);
        run_dec(int'(tmp_w[16:0]));
        chk(dec_mult == 16'd32000, "R7 round trip", dec_mult, 32000);
        ref_encode(32768, tmp_w, tmp_s);
        run_dec(int'(tmp_w[16:0]));
        chk(dec_mult == 16'd32768, "R7 round trip max", dec_mult, 32768);
        run_dec('h4000);
        chk(dec_mult == 16'h8001, "R7 seed decodes to 32769", dec_mult, 'h8001);

        // R9: starts while busy are ignored
        held_word = enc_word;
        @(negedge clk);
        ref_encode(32000, tmp_w, tmp_s);
        dec_code = tmp_w[16:0]; dec_start = 1'b1;
        @(negedge clk);
        dec_start = 1'b0;
        repeat (5) @(negedge clk);
        enc_mult = 16'd1; enc_start = 1'b1;
        @(negedge clk);
        enc_start = 1'b0;
        wait_idle();
        chk(enc_word == held_word, "R9 ignored encode", enc_word, held_word);

        // R10: simultaneous starts, encode wins
        held_mult = dec_mult;
        @(negedge clk);
        enc_mult = 16'd32768; enc_start = 1'b1;
        dec_code = 17'h18003; dec_start = 1'b1;
        @(negedge clk);
        enc_start = 1'b0; dec_start = 1'b0;
        wait_idle();
        chk(dec_mult == held_mult, "R10 decode dropped", dec_mult, held_mult);

        // R8: a code outside the sequence
        run_dec(0);
        chk(dec_invalid == 1'b1, "R8 invalid flag", dec_invalid, 1);
        run_dec('h10003);
        chk(dec_invalid == 1'b0, "R8 flag clears", dec_invalid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule